// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block sits beside a DRAM memory arbiter and makes sure that each of the device's rows is refreshed within the retention window. An interval timer divides the window into one slot per row. In each slot it adds one refresh to a pending count. While that count is non-zero the block raises a request to the arbiter. Each grant the arbiter returns retires one pending refresh.

Two refresh styles are supported, and a mode input selects between them. In RAS-only mode the controller must supply the row, so the block keeps its own row pointer, presents it on `row_addr`, and advances it after every granted refresh. In CAS-before-RAS mode the device counts rows internally, so the pointer is left untouched. Refreshes that the arbiter holds off are banked up to a parameterised limit. If another slot expires with the bank already full, a sticky overdue flag is raised, because a row can then miss its deadline.

Top module: `rfsh_sched`

## Requirements
- R1: After a synchronous reset, `pending` is 0, `req` is 0, `row_addr` is 0 and `overdue` is 0.
- R2: The refresh interval is INTERVAL = CLK_KHZ*WINDOW_US/(1000*ROWS) clocks. `pending` first increments on the (INTERVAL+1)th rising edge after reset is released, and again every INTERVAL edges after that.
- R3: `req` is 1 exactly when `pending` is non-zero.
- R4: A rising edge with `grant`=1 while `req`=1 lowers `pending` by one. A `grant` while `req`=0 changes neither `pending` nor `row_addr`.
- R5: When a slot expires on the same edge that a grant is consumed, `pending` is left unchanged.
- R6: With `ras_only_mode`=1, each consumed grant advances `row_addr` by one, and the pointer wraps from ROWS-1 to 0.
- R7: With `ras_only_mode`=0 (CAS-before-RAS), a consumed grant leaves `row_addr` unchanged.
- R8: When a slot expires with `pending` equal to PEND_MAX and no grant is consumed, `pending` stays at PEND_MAX and `overdue` becomes 1. `overdue` then stays 1 until reset.
- R9: `pending` never exceeds PEND_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_mode | input | 1 | 1 selects RAS-only refresh (controller-supplied row); 0 selects CAS-before-RAS |
| grant | input | 1 | Arbiter accepts the outstanding refresh request |
| req | output | 1 | Refresh request to the arbiter |
| row_addr | output | $clog2(ROWS) | Row to refresh in RAS-only mode |
| pending | output | $clog2(PEND_MAX+1) | Number of refreshes owed |
| overdue | output | 1 | Sticky flag: a refresh slot was lost |

## Verification
The bench lands a slot expiry on the same edge as a grant. A design that counted both would drift its pending count by one. It holds `grant` high while nothing is pending, which catches a design that lets a spurious grant retire a future refresh or step the row pointer. It fills the bank until a further slot overflows it, expecting the count to saturate and the flag to stay set after grants drain the bank. It then runs 512 back-to-back RAS-only refreshes to see the pointer reach 511 and wrap to 0. An off-by-one in the interval divider shows up when the first increment arrives on the wrong edge.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  // clocks between refresh slots: window spread evenly over all rows
  function automatic int calc_interval(input int clk_khz, input int window_us,
                                       input int rows);
    return (clk_khz * window_us) / (1000 * rows);
  endfunction
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  generate
    if (INTERVAL > 1) begin : g_gap
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend #(
  parameter int PEND_MAX = 8,
  localparam int CW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          take,
  output logic [CW-1:0] pend,
  output logic          overdue
);
  localparam logic [CW-1:0] FULL = CW'(PEND_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      overdue <= 1'b0;
    end else begin
      if (tick && !take) begin
        if (pend == FULL) overdue <= 1'b1;
        else              pend    <= pend + 1'b1;
      end else if (take && !tick) begin
        pend <= pend - 1'b1;
      end
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    pend <= FULL);
  p_take_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (take && !tick) |=> (pend == $past(pend) - 1'b1));
  p_tick_and_take_r5: assert property (@(posedge clk) disable iff (rst)
    (take && tick) |=> $stable(pend));
  p_overdue_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overdue |=> overdue);
endmodule

// File: rtl/rfsh_row.sv
module rfsh_row #(
  parameter int ROWS = 512,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [RW-1:0] row
);
  localparam logic [RW-1:0] TOP = RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst)       row <= '0;
    else if (step) row <= (row == TOP) ? '0 : row + 1'b1;
  end

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (step && row == TOP) |=> (row == '0));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(row));
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int CLK_KHZ   = 100000,
  parameter int WINDOW_US = 8000,
  parameter int ROWS      = 512,
  parameter int PEND_MAX  = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_only_mode,
  input  logic          grant,
  output logic          req,
  output logic [RW-1:0] row_addr,
  output logic [CW-1:0] pending,
  output logic          overdue
);
  localparam int INTERVAL = rfsh_pkg::calc_interval(CLK_KHZ, WINDOW_US, ROWS);

  logic tick;
  logic take;

  assign req  = (pending != '0);
  assign take = grant && req;

  rfsh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  rfsh_pend #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .take   (take),
    .pend   (pending),
    .overdue(overdue)
  );

  rfsh_row #(.ROWS(ROWS)) u_row (
    .clk (clk),
    .rst (rst),
    .step(take && ras_only_mode),
    .row (row_addr)
  );

  p_cbr_row_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ras_only_mode |=> $stable(row_addr));
  p_idle_grant_r4: assert property (@(posedge clk) disable iff (rst)
    (grant && !req) |=> $stable(row_addr));
endmodule

// File: tb/sim_rfsh_sched.sv
module sim_rfsh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 512;
  localparam int PEND_MAX   = 3;
  // 640 kHz * 8000 us / (1000*512) = 10 clocks per slot
  localparam int CLK_KHZ    = 640;
  localparam int WINDOW_US  = 8000;

  typedef struct packed {
    logic        mode;
    logic        gnt;
    logic [15:0] cycles;
    logic [3:0]  exp_pend;
    logic [8:0]  exp_row;
    logic        exp_ovd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 16'd10, 4'd0, 9'd0, 1'b0},  // R2 no slot yet at edge 10
    '{1'b1, 1'b0, 16'd1,  4'd1, 9'd0, 1'b0},  // R2 first slot at edge 11
    '{1'b1, 1'b1, 16'd1,  4'd0, 9'd1, 1'b0},  // R4 R6 grant consumed
    '{1'b1, 1'b1, 16'd9,  4'd1, 9'd1, 1'b0},  // R4 idle grants ignored
    '{1'b1, 1'b1, 16'd1,  4'd0, 9'd2, 1'b0},  // R6
    '{1'b0, 1'b0, 16'd9,  4'd1, 9'd2, 1'b0},  // R2
    '{1'b0, 1'b1, 16'd1,  4'd0, 9'd2, 1'b0},  // R7 CBR row held
    '{1'b1, 1'b0, 16'd30, 4'd3, 9'd2, 1'b0},  // R3 bank fills
    '{1'b1, 1'b0, 16'd10, 4'd3, 9'd2, 1'b1},  // R8 overflow flagged
    '{1'b1, 1'b1, 16'd3,  4'd0, 9'd5, 1'b1},  // R8 sticky, R6
    '{1'b1, 1'b0, 16'd6,  4'd1, 9'd5, 1'b1},  // R2
    '{1'b1, 1'b0, 16'd9,  4'd1, 9'd5, 1'b1},  // R3
    '{1'b1, 1'b1, 16'd1,  4'd1, 9'd6, 1'b1}   // R5 slot and grant together
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_only_mode = 1'b1;
  logic       grant = 1'b0;
  logic       req;
  logic [8:0] row_addr;
  logic [1:0] pending;
  logic       overdue;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfsh_sched #(.CLK_KHZ(CLK_KHZ), .WINDOW_US(WINDOW_US), .ROWS(ROWS),
               .PEND_MAX(PEND_MAX)) u0 (
    .clk(clk), .rst(rst), .ras_only_mode(ras_only_mode), .grant(grant),
    .req(req), .row_addr(row_addr), .pending(pending), .overdue(overdue)
  );

  task automatic check(input string tag, input int p, input int r, input int o);
    int q;
    q = (p != 0) ? 1 : 0;
    n_chk++;
    if (int'(pending) != p || int'(row_addr) != r || int'(overdue) != o ||
        int'(req) != q) begin
      n_bad++;
      $display("FAIL %s: pend=%0d row=%0d ovd=%0d req=%0d expected pend=%0d row=%0d ovd=%0d req=%0d",
               tag, pending, row_addr, overdue, req, p, r, o, q);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    grant = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    check("R1 reset state", 0, 0, 0);
    for (int i = 0; i < NV; i++) begin
      ras_only_mode = VEC[i].mode;
      grant = VEC[i].gnt;
      repeat (int'(VEC[i].cycles)) @(posedge clk);
      @(negedge clk);
      check($sformatf("R2-table vector %0d", i), int'(VEC[i].exp_pend),
            int'(VEC[i].exp_row), int'(VEC[i].exp_ovd));
    end

    // R1 reset mid-run clears the sticky flag and the row pointer
    do_reset();
    check("R1 reset after overdue", 0, 0, 0);

    // R6 back-to-back RAS-only refreshes: grant k lands on edge 10k+2
    ras_only_mode = 1'b1;
    grant = 1'b1;
    repeat (5115) @(posedge clk);
    @(negedge clk);
    check("R6 row reaches 511", 0, 511, 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R6 row wraps to 0", 0, 0, 0);
    grant = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule